// File: doc/BRIEF.md
# Clock Generator Divider Update Sequencer

This block sits on the host side of a serially configured PLL clock generator. It is used to move that generator to a new set of divider values. A single request carries four values: the 7-bit integer feedback value N, the 17-bit fractional feedback value F, and the two 8-bit output dividers M1 and M2. The block checks that the output dividers are legal. It then runs a fixed series of byte writes through a plain request/acknowledge port. The serial physical layer behind that port is outside this block.

The series has three phases. First, the generator is put into its low-power state by setting the low-power bit in its control byte. Then the block waits a fixed time, given in nanoseconds and turned into clock cycles by rounding up. After the wait, the divider bytes are written in ascending address order, and the low-power bit is cleared again. The other bits of the control byte keep their values, because the block holds its own copy of that byte. A build-time option drops the second output divider for targets that have only one output.

Top module: `osc_freq_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and wr_req_o are all low.
- R2: A request taken while idle with legal dividers raises busy_o in the next cycle. The first write then goes to address CTRL_ADDR (0x10). Its data is the held copy of the control byte with bit HIB_BIT (5) set.
- R3: After the acknowledge of the low-power-set write, no write request is raised for at least WAIT_CYC cycles, where WAIT_CYC = ceil(CLK_HZ x WAIT_NS / 1e9).
- R4: The divider bytes are written in this order: 0x13 = F[7:0], 0x14 = F[15:8], 0x15 = {N[6:0], F[16]} (N in bits 7:1, F[16] in bit 0), 0x16 = M1, and then, when DUAL_OUT=1, 0x17 = M2.
- R5: With DUAL_OUT=0, address 0x17 is never written, and the low-power-clear write follows directly after 0x16.
- R6: The last write goes to 0x10 with bit 5 cleared. All other bits of the control byte equal their held values, which start at CTRL_RST after reset.
- R7: While wr_req_o is high and wr_ack_i is low, wr_req_o, wr_addr_o and wr_data_o stay unchanged. Each acknowledge completes exactly one write.
- R8: done_o is high for exactly one cycle. That cycle directly follows the acknowledge of the low-power-clear write, and busy_o is low in the same cycle.
- R9: An idle request with M1 outside [2,127] is rejected. The same holds for M2 outside [2,127], but only when DUAL_OUT=1. A rejected request gives a one-cycle err_o pulse in the next cycle and starts no write. With DUAL_OUT=0, M2 is not checked.
- R10: While busy, requests and changes on n_i, f_i, m1_i and m2_i have no effect on the bytes that are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Update request, sampled while idle |
| n_i | input | 7 | Integer feedback value N |
| f_i | input | 17 | Fractional feedback value F |
| m1_i | input | 8 | Divider for output 1 |
| m2_i | input | 8 | Divider for output 2 |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle pulse when an update completes |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| wr_req_o | output | 1 | Byte write request to the serial layer |
| wr_addr_o | output | 8 | Register address of the pending write |
| wr_data_o | output | 8 | Data byte of the pending write |
| wr_ack_i | input | 1 | Serial layer has accepted the pending write |

## Verification
The bench uses several kinds of divider sets, each chosen to expose a different fault:
- F values with bit 16 set and with bit 16 clear, which show whether F[16] is packed correctly next to N.
- All-ones values of N and F, which reveal bits shifted into the wrong byte.
- M values exactly at the edges of the legal range, and one step outside them on each side, which separate off-by-one errors in the range check from correct rejection.
- An acknowledge latency that rotates between zero and two stall cycles, which tests that a write is held stable while waiting.
- Requests and input changes sent while the block is busy, which show whether the values are latched at the start or read live.
- Both a dual-output and a single-output build, each with a different starting control byte, which show both that address 0x17 is skipped and that the other control bits are preserved.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

  localparam int unsigned N_W = 7;
  localparam int unsigned F_W = 17;
  localparam int unsigned M_W = 8;
  localparam int unsigned A_W = 8;
  localparam int unsigned D_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT
  } seq_state_e;

  // step order is the write order; freq steps map to FREQ_BASE + step - 1
  typedef enum logic [2:0] {
    STEP_HIB_ON  = 3'd0,
    STEP_F_LO    = 3'd1,
    STEP_F_MID   = 3'd2,
    STEP_N_FHI   = 3'd3,
    STEP_M1      = 3'd4,
    STEP_M2      = 3'd5,
    STEP_HIB_OFF = 3'd6
  } step_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [F_W-1:0] f;
    logic [M_W-1:0] m1;
    logic [M_W-1:0] m2;
  } div_cfg_t;

endpackage

// File: rtl/osc_seq_range.sv
module osc_seq_range
  import osc_seq_pkg::*;
#(
  parameter bit          DUAL_OUT = 1'b1,
  parameter int unsigned M_MIN    = 2,
  parameter int unsigned M_MAX    = 127
) (
  input  logic [M_W-1:0] m1_i,
  input  logic [M_W-1:0] m2_i,
  output logic           ok_o
);

  function automatic logic in_rng(input logic [M_W-1:0] m);
    return (32'(m) >= M_MIN) && (32'(m) <= M_MAX);
  endfunction

  generate
    if (DUAL_OUT) begin : g_dual
      assign ok_o = in_rng(m1_i) && in_rng(m2_i);
    end else begin : g_single
      assign ok_o = in_rng(m1_i);
    end
  endgenerate

endmodule

// File: rtl/osc_seq_timer.sv
module osc_seq_timer #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/osc_seq_pack.sv
module osc_seq_pack
  import osc_seq_pkg::*;
#(
  parameter bit             DUAL_OUT  = 1'b1,
  parameter logic [A_W-1:0] CTRL_ADDR = 8'h10,
  parameter int unsigned    HIB_BIT   = 5,
  parameter logic [A_W-1:0] FREQ_BASE = 8'h13
) (
  input  step_e          step_i,
  input  div_cfg_t       cfg_i,
  input  logic [D_W-1:0] shadow_i,
  output logic [A_W-1:0] addr_o,
  output logic [D_W-1:0] data_o
);

  localparam logic [D_W-1:0] HIB_MASK = D_W'(1) << HIB_BIT;

  logic [D_W-1:0] m2_byte;

  generate
    if (DUAL_OUT) begin : g_m2
      assign m2_byte = cfg_i.m2;
    end else begin : g_no_m2
      assign m2_byte = '0;
    end
  endgenerate

  always_comb begin
    addr_o = FREQ_BASE + A_W'(step_i) - A_W'(1);
    data_o = '0;
    unique case (step_i)
      STEP_HIB_ON: begin
        addr_o = CTRL_ADDR;
        data_o = shadow_i | HIB_MASK;
      end
      STEP_F_LO:  data_o = cfg_i.f[7:0];
      STEP_F_MID: data_o = cfg_i.f[15:8];
      STEP_N_FHI: data_o = {cfg_i.n, cfg_i.f[16]};
      STEP_M1:    data_o = cfg_i.m1;
      STEP_M2:    data_o = m2_byte;
      default: begin
        addr_o = CTRL_ADDR;
        data_o = shadow_i & ~HIB_MASK;
      end
    endcase
  end

endmodule

// File: rtl/osc_freq_seq.sv
module osc_freq_seq
  import osc_seq_pkg::*;
#(
  parameter int unsigned    CLK_HZ    = 50_000_000,
  parameter int unsigned    WAIT_NS   = 100_000,
  parameter bit             DUAL_OUT  = 1'b1,
  parameter logic [A_W-1:0] CTRL_ADDR = 8'h10,
  parameter int unsigned    HIB_BIT   = 5,
  parameter logic [A_W-1:0] FREQ_BASE = 8'h13,
  parameter logic [D_W-1:0] CTRL_RST  = 8'h00,
  parameter int unsigned    M_MIN     = 2,
  parameter int unsigned    M_MAX     = 127
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [N_W-1:0] n_i,
  input  logic [F_W-1:0] f_i,
  input  logic [M_W-1:0] m1_i,
  input  logic [M_W-1:0] m2_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic           wr_req_o,
  output logic [A_W-1:0] wr_addr_o,
  output logic [D_W-1:0] wr_data_o,
  input  logic           wr_ack_i
);

  localparam longint unsigned WAIT_PROD = longint'(CLK_HZ) * longint'(WAIT_NS);
  localparam int unsigned WAIT_RAW =
    int'((WAIT_PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam step_e LAST_FREQ = DUAL_OUT ? STEP_M2 : STEP_M1;

  seq_state_e     state_q;
  step_e          step_q;
  div_cfg_t       cfg_q;
  logic [D_W-1:0] shadow_q;
  logic           done_q, err_q;
  logic           cfg_ok, wait_done, ack_hib_on, ctrl_step;

  osc_seq_range #(
    .DUAL_OUT (DUAL_OUT),
    .M_MIN    (M_MIN),
    .M_MAX    (M_MAX)
  ) u_range (
    .m1_i (m1_i),
    .m2_i (m2_i),
    .ok_o (cfg_ok)
  );

  osc_seq_pack #(
    .DUAL_OUT  (DUAL_OUT),
    .CTRL_ADDR (CTRL_ADDR),
    .HIB_BIT   (HIB_BIT),
    .FREQ_BASE (FREQ_BASE)
  ) u_pack (
    .step_i   (step_q),
    .cfg_i    (cfg_q),
    .shadow_i (shadow_q),
    .addr_o   (wr_addr_o),
    .data_o   (wr_data_o)
  );

  assign ack_hib_on = (state_q == ST_WRITE) && wr_ack_i && (step_q == STEP_HIB_ON);

  osc_seq_timer #(
    .CYCLES (WAIT_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ack_hib_on),
    .expire_o (wait_done)
  );

  assign ctrl_step = (step_q == STEP_HIB_ON) || (step_q == STEP_HIB_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= STEP_HIB_ON;
      cfg_q    <= '0;
      shadow_q <= CTRL_RST;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (cfg_ok) begin
              cfg_q   <= '{n: n_i, f: f_i, m1: m1_i, m2: m2_i};
              step_q  <= STEP_HIB_ON;
              state_q <= ST_WRITE;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ack_i) begin
            // shadow follows what the target register now holds
            if (ctrl_step) shadow_q <= wr_data_o;
            if (step_q == STEP_HIB_ON) begin
              state_q <= ST_WAIT;
            end else if (step_q == STEP_HIB_OFF) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (step_q == LAST_FREQ) begin
              step_q <= STEP_HIB_OFF;
            end else begin
              step_q <= step_e'(3'(step_q + 3'd1));
            end
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            state_q <= ST_WRITE;
            step_q  <= STEP_F_LO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign wr_req_o = (state_q == ST_WRITE);
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/osc_freq_seq_chk.sv
module osc_freq_seq_chk
  import osc_seq_pkg::*;
#(
  parameter int unsigned    WAIT_CYC  = 1,
  parameter logic [A_W-1:0] CTRL_ADDR = 8'h10,
  parameter int unsigned    HIB_BIT   = 5,
  parameter logic [A_W-1:0] FREQ_BASE = 8'h13,
  parameter int unsigned    M_MIN     = 2,
  parameter int unsigned    M_MAX     = 127
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic           wr_req_o,
  input logic [A_W-1:0] wr_addr_o,
  input logic [D_W-1:0] wr_data_o,
  input logic           wr_ack_i
);

  localparam int unsigned GAP_W = $clog2(WAIT_CYC + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [A_W-1:0] M1_ADDR = FREQ_BASE + A_W'(3);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (wr_req_o && wr_ack_i && wr_addr_o == CTRL_ADDR && wr_data_o[HIB_BIT])
      gap_q <= '0;
    else if (gap_q != GAP_MAX)
      gap_q <= gap_q + 1'b1;
  end

  assert_first_hib_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wr_req_o && wr_addr_o == CTRL_ADDR && wr_data_o[HIB_BIT]);

  assert_start_by_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  assert_wait_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_addr_o == FREQ_BASE) |-> (32'(gap_q) >= WAIT_CYC));

  assert_hib_clear_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_addr_o) == CTRL_ADDR && !$past(wr_data_o[HIB_BIT]));

  assert_hold_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_req_only_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> busy_o);

  assert_done_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && $past(wr_ack_i));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !wr_req_o && $past(req_i) && !$past(busy_o));

  assert_m1_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_addr_o == M1_ADDR) |-> 32'(wr_data_o) >= M_MIN && 32'(wr_data_o) <= M_MAX);

endmodule

bind osc_freq_seq osc_freq_seq_chk #(
  .WAIT_CYC  (WAIT_CYC),
  .CTRL_ADDR (CTRL_ADDR),
  .HIB_BIT   (HIB_BIT),
  .FREQ_BASE (FREQ_BASE),
  .M_MIN     (M_MIN),
  .M_MAX     (M_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .wr_req_o  (wr_req_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .wr_ack_i  (wr_ack_i)
);

// File: tb/osc_freq_seq_tb.sv
module osc_freq_seq_tb;

  localparam int WAIT_NS  = 2000;
  localparam int WAIT_CYC = 100;   // 2000 ns at 20 ns per cycle
  localparam logic [7:0] SH_D = 8'h81;
  localparam logic [7:0] SH_S = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10ns clk = ~clk;

  logic        req_d = 1'b0, req_s = 1'b0;
  logic [6:0]  n  = '0;
  logic [16:0] f  = '0;
  logic [7:0]  m1 = '0, m2 = '0;

  logic busy_d, done_d, err_d, wrq_d, ack_d = 1'b0;
  logic busy_s, done_s, err_s, wrq_s, ack_s = 1'b0;
  logic [7:0] wa_d, wd_d, wa_s, wd_s;

  int vec = 0, bad = 0;
  longint cyc = 0;
  logic [15:0] exp_d[$], exp_s[$];

  osc_freq_seq #(.WAIT_NS(WAIT_NS), .DUAL_OUT(1'b1), .CTRL_RST(SH_D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_d), .n_i(n), .f_i(f), .m1_i(m1), .m2_i(m2),
    .busy_o(busy_d), .done_o(done_d), .err_o(err_d), .wr_req_o(wrq_d),
    .wr_addr_o(wa_d), .wr_data_o(wd_d), .wr_ack_i(ack_d));

  osc_freq_seq #(.WAIT_NS(WAIT_NS), .DUAL_OUT(1'b0), .CTRL_RST(SH_S)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_s), .n_i(n), .f_i(f), .m1_i(m1), .m2_i(m2),
    .busy_o(busy_s), .done_o(done_s), .err_o(err_s), .wr_req_o(wrq_s),
    .wr_addr_o(wa_s), .wr_data_o(wd_s), .wr_ack_i(ack_s));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [15:0] e);
    if (e[15:8] == 8'h10) return e[5] ? "R2" : "R6";
    if (e[15:8] == 8'h17) return "R4";
    return "R4";
  endfunction

  always @(posedge clk) cyc++;

  // responder and per-cycle reference compare, dual-output target
  int gap_d = 0, sp_d = 1;
  bit held_d = 0, pend_d = 0;
  logic [15:0] last_d;
  longint hib_d = 0;
  always @(negedge clk) begin
    logic [15:0] got, e;
    got = {wa_d, wd_d};
    if (pend_d) begin
      if (wrq_d && wa_d == 8'h13) begin
        chk(cyc - hib_d >= WAIT_CYC + 1, "R3", "dual wait length", cyc - hib_d, WAIT_CYC + 1);
        pend_d = 0;
      end else if (cyc != hib_d) begin
        chk(!wrq_d, "R3", "dual write during wait", got, 0);
      end
    end
    if (ack_d) begin
      ack_d <= 1'b0;
      held_d = 0;
    end else if (wrq_d) begin
      if (held_d) chk(got == last_d, "R7", "dual held write changed", got, last_d);
      if (gap_d == 0) begin
        ack_d <= 1'b1;
        held_d = 0;
        gap_d = sp_d % 3;
        sp_d++;
        if (exp_d.size() == 0) chk(1'b0, "R9", "dual unexpected write", got, 0);
        else begin
          e = exp_d.pop_front();
          chk(got == e, tag_of(e), "dual write", got, e);
        end
        if (wa_d == 8'h10 && wd_d[5]) begin hib_d = cyc; pend_d = 1; end
      end else begin
        gap_d--;
        held_d = 1;
        last_d = got;
      end
    end
  end

  // responder and per-cycle reference compare, single-output target
  int gap_s = 0, sp_s = 2;
  bit held_s = 0, pend_s = 0;
  logic [15:0] last_s;
  longint hib_s = 0;
  always @(negedge clk) begin
    logic [15:0] got, e;
    got = {wa_s, wd_s};
    if (wrq_s) chk(wa_s != 8'h17, "R5", "single wrote second divider", got, 0);
    if (pend_s) begin
      if (wrq_s && wa_s == 8'h13) begin
        chk(cyc - hib_s >= WAIT_CYC + 1, "R3", "single wait length", cyc - hib_s, WAIT_CYC + 1);
        pend_s = 0;
      end else if (cyc != hib_s) begin
        chk(!wrq_s, "R3", "single write during wait", got, 0);
      end
    end
    if (ack_s) begin
      ack_s <= 1'b0;
      held_s = 0;
    end else if (wrq_s) begin
      if (held_s) chk(got == last_s, "R7", "single held write changed", got, last_s);
      if (gap_s == 0) begin
        ack_s <= 1'b1;
        held_s = 0;
        gap_s = sp_s % 3;
        sp_s++;
        if (exp_s.size() == 0) chk(1'b0, "R9", "single unexpected write", got, 0);
        else begin
          e = exp_s.pop_front();
          chk(got == e, (e[15:8] == 8'h10 && !e[5]) ? "R5" : tag_of(e), "single write", got, e);
        end
        if (wa_s == 8'h10 && wd_s[5]) begin hib_s = cyc; pend_s = 1; end
      end else begin
        gap_s--;
        held_s = 1;
        last_s = got;
      end
    end
  end

  task automatic push_exp(input bit dual, input logic [6:0] nn, input logic [16:0] ff,
                          input logic [7:0] a, input logic [7:0] b);
    logic [7:0] sh;
    logic [15:0] l[$];
    sh = dual ? SH_D : SH_S;
    l.push_back({8'h10, sh | 8'h20});
    l.push_back({8'h13, ff[7:0]});
    l.push_back({8'h14, ff[15:8]});
    l.push_back({8'h15, nn, ff[16]});
    l.push_back({8'h16, a});
    if (dual) l.push_back({8'h17, b});
    l.push_back({8'h10, sh & 8'hDF});
    foreach (l[i]) begin
      if (dual) exp_d.push_back(l[i]);
      else      exp_s.push_back(l[i]);
    end
  endtask

  task automatic do_update(input bit dual, input logic [6:0] nn, input logic [16:0] ff,
                           input logic [7:0] a, input logic [7:0] b, input bit poke);
    n = nn; f = ff; m1 = a; m2 = b;
    push_exp(dual, nn, ff, a, b);
    if (dual) req_d = 1'b1; else req_s = 1'b1;
    @(negedge clk);
    req_d = 1'b0; req_s = 1'b0;
    chk(dual ? busy_d : busy_s, "R2", "busy after request", dual ? busy_d : busy_s, 1);
    if (poke) begin
      // R10: new values and requests while busy
      n = ~nn; f = ~ff; m1 = 8'd3; m2 = 8'd9;
      for (int i = 0; i < 4; i++) begin
        if (dual) req_d = 1'b1; else req_s = 1'b1;
        @(negedge clk);
        chk(!(dual ? err_d : err_s), "R10", "err while busy", 1, 0);
      end
      req_d = 1'b0; req_s = 1'b0;
    end
    while (dual ? busy_d : busy_s) @(negedge clk);
    chk(dual ? done_d : done_s, "R8", "done with busy low", 0, 1);
    chk((dual ? exp_d.size() : exp_s.size()) == 0, "R4", "writes left",
        dual ? exp_d.size() : exp_s.size(), 0);
    @(negedge clk);
    chk(!(dual ? done_d : done_s), "R8", "done longer than one cycle", 1, 0);
    chk(!(dual ? busy_d : busy_s), "R10", "restarted by stale request", 1, 0);
  endtask

  task automatic do_bad(input bit dual, input logic [7:0] a, input logic [7:0] b);
    m1 = a; m2 = b; n = 7'd66; f = 17'h15555;
    if (dual) req_d = 1'b1; else req_s = 1'b1;
    @(negedge clk);
    req_d = 1'b0; req_s = 1'b0;
    chk(dual ? err_d : err_s, "R9", "err pulse", 0, 1);
    chk(!(dual ? busy_d : busy_s), "R9", "busy on rejected request", 1, 0);
    @(negedge clk);
    chk(!(dual ? err_d : err_s), "R9", "err longer than one cycle", 1, 0);
    chk(!(dual ? wrq_d : wrq_s), "R9", "write after rejection", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_d && !done_d && !err_d && !wrq_d, "R1", "dual reset outputs",
        {busy_d, done_d, err_d, wrq_d}, 0);
    chk(!busy_s && !done_s && !err_s && !wrq_s, "R1", "single reset outputs",
        {busy_s, done_s, err_s, wrq_s}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_update(1'b1, 7'd66, 17'h15555, 8'd24, 8'd24, 1'b1);
    do_update(1'b1, 7'd69, 17'h0E38E, 8'd5, 8'd25, 1'b0);
    do_update(1'b1, 7'd127, 17'h1FFFF, 8'd2, 8'd127, 1'b0);   // R9 edges accepted

    do_bad(1'b1, 8'd1, 8'd24);
    do_bad(1'b1, 8'd128, 8'd24);
    do_bad(1'b1, 8'd24, 8'd1);
    do_bad(1'b1, 8'd24, 8'd200);
    do_bad(1'b0, 8'd0, 8'd24);
    do_bad(1'b0, 8'd255, 8'd24);

    // R5: single target ignores M2, even an illegal one (R9)
    do_update(1'b0, 7'd94, 17'h1E38E, 8'd127, 8'd0, 1'b0);
    do_update(1'b0, 7'd0, 17'h00000, 8'd2, 8'd255, 1'b1);
    do_update(1'b1, 7'd88, 17'h0C71C, 8'd20, 8'd24, 1'b1);

    repeat (5) @(negedge clk);
    chk(exp_d.size() == 0 && exp_s.size() == 0, "R4", "pending expected writes",
        exp_d.size() + exp_s.size(), 0);
    finish_run();
  end

endmodule